// File: doc/BRIEF.md
# Funnel Shifter with Six Shift Modes

This block is a purely combinational N-bit shifter. It handles logical, arithmetic and rotating shifts in both directions. All six kinds use one datapath. A (2N-1)-bit funnel word is built from the operand, with the fill depending on the mode. An N-bit window is then taken from that word at a binary offset.

Right shifts use the shift amount as the offset. Left shifts use the complement offset N-k, reduced modulo N. The window is picked by log2(N) stages of 2:1 multiplexers. Stage s moves the word down by 2^s positions when offset bit s is set, so no one-hot decode of the amount is needed.

The shift amount covers 0 to N-1. N must be a power of two and at least 2, and elaboration fails otherwise.

Top module: `fsh_funnel_shifter`

## Requirements
- R1: With mode_i = 3'b000 (logical left), res_o equals opnd_i shifted toward the MSB by amt_i, with zeros entering at the LSB end and the top bits discarded.
- R2: With mode_i = 3'b001 (logical right), res_o equals opnd_i shifted toward the LSB by amt_i, with zeros entering at the MSB end.
- R3: With mode_i = 3'b010 (arithmetic left), res_o is identical to the logical left result for the same operand and amount.
- R4: With mode_i = 3'b011 (arithmetic right), res_o equals opnd_i shifted toward the LSB by amt_i, with copies of opnd_i[N-1] entering at the MSB end.
- R5: With mode_i = 3'b100 (rotate left), bit j of res_o equals bit (j - amt_i) mod N of opnd_i.
- R6: With mode_i = 3'b101 (rotate right), bit j of res_o equals bit (j + amt_i) mod N of opnd_i.
- R7: When amt_i is 0, res_o equals opnd_i in every one of the six modes.
- R8: The codes 3'b110 and 3'b111 pass opnd_i through unchanged, whatever the value of amt_i.
- R9: The block holds no state. res_o follows a change on any input within the same cycle, and the result does not depend on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | N | Operand to be shifted |
| amt_i | input | log2(N) | Shift amount, 0 to N-1 |
| mode_i | input | 3 | Shift kind: 000 lsl, 001 lsr, 010 asl, 011 asr, 100 rol, 101 ror, 11x pass |
| res_o | output | N | Shifted result |

## Verification
There is no storage, so a wrong internal value shows up at res_o in the same cycle as the input that exposes it. The faults most likely to appear are these:
- A wrong funnel fill shows as bad bits at the vacated end of the result, for example zeros where sign copies belong.
- A wrong offset shows as a result displaced by the wrong amount, which is most visible for left shifts and small amounts.
- A miswired mux stage corrupts every amount that has that offset bit set.

Sweeping every operand, amount and mode code exposes each of these faults on the first input vector that triggers it.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

   typedef enum logic [2:0] {
      SH_LSL  = 3'b000,
      SH_LSR  = 3'b001,
      SH_ASL  = 3'b010,
      SH_ASR  = 3'b011,
      SH_ROL  = 3'b100,
      SH_ROR  = 3'b101,
      SH_PASA = 3'b110,
      SH_PASB = 3'b111
   } sh_mode_e;

   function automatic logic is_left(input sh_mode_e m);
      return (m == SH_LSL) || (m == SH_ASL) || (m == SH_ROL);
   endfunction

   function automatic logic is_right(input sh_mode_e m);
      return (m == SH_LSR) || (m == SH_ASR) || (m == SH_ROR);
   endfunction

endpackage

// File: rtl/fsh_funnel_build.sv
module fsh_funnel_build
   import fsh_pkg::*;
#(
   parameter int N = 8,
   localparam int FW = 2 * N - 1
) (
   input  logic [N-1:0]  opnd,
   input  sh_mode_e      mode,
   input  logic          amt_zero,
   output logic [FW-1:0] word
);

   logic [N-2:0] upper;
   logic [N-1:0] lower;

   always_comb begin
      upper = '0;
      lower = opnd;
      unique case (mode)
         SH_LSL, SH_ASL: begin
            upper = opnd[N-2:0];
            lower = amt_zero ? opnd : '0;
         end
         SH_LSR: begin
            upper = '0;
            lower = opnd;
         end
         SH_ASR: begin
            upper = {(N-1){opnd[N-1]}};
            lower = opnd;
         end
         SH_ROL, SH_ROR: begin
            upper = opnd[N-2:0];
            lower = opnd;
         end
         default: begin
            upper = '0;
            lower = opnd;
         end
      endcase
   end

   assign word = {upper, lower};

endmodule

// File: rtl/fsh_offset.sv
module fsh_offset
   import fsh_pkg::*;
#(
   parameter int N = 8,
   localparam int KW = $clog2(N)
) (
   input  sh_mode_e      mode,
   input  logic [KW-1:0] amt,
   output logic [KW-1:0] off
);

   always_comb begin
      if (is_left(mode)) begin
         off = KW'(0) - amt;
      end else if (is_right(mode)) begin
         off = amt;
      end else begin
         off = '0;
      end
   end

endmodule

// File: rtl/fsh_mux_stage.sv
module fsh_mux_stage #(
   parameter int W_IN  = 15,
   parameter int SHIFT = 1,
   localparam int W_OUT = W_IN - SHIFT
) (
   input  logic [W_IN-1:0]  din,
   input  logic             sel,
   output logic [W_OUT-1:0] dout
);

   for (genvar i = 0; i < W_OUT; i++) begin : g_bit
      assign dout[i] = sel ? din[i + SHIFT] : din[i];
   end

endmodule

// File: rtl/fsh_funnel_shifter.sv
module fsh_funnel_shifter
   import fsh_pkg::*;
#(
   parameter int N = 8,
   localparam int KW = $clog2(N),
   localparam int FW = 2 * N - 1
) (
   input  logic [N-1:0]  opnd_i,
   input  logic [KW-1:0] amt_i,
   input  logic [2:0]    mode_i,
   output logic [N-1:0]  res_o
);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_width
      $error("fsh_funnel_shifter: N must be a power of two and at least 2");
   end

   sh_mode_e      mode;
   logic [FW-1:0] word;
   logic [KW-1:0] off;

   assign mode = sh_mode_e'(mode_i);

   fsh_funnel_build #(.N(N)) u_build (
      .opnd     (opnd_i),
      .mode     (mode),
      .amt_zero (amt_i == '0),
      .word     (word)
   );

   fsh_offset #(.N(N)) u_off (
      .mode (mode),
      .amt  (amt_i),
      .off  (off)
   );

   for (genvar s = 0; s < KW; s++) begin : g_stage
      localparam int WI = 2 * N - (1 << s);
      localparam int WO = WI - (1 << s);
      logic [WO-1:0] q;
      if (s == 0) begin : g_first
         fsh_mux_stage #(.W_IN(WI), .SHIFT(1 << s)) u_mux (
            .din  (word),
            .sel  (off[s]),
            .dout (q)
         );
      end else begin : g_next
         fsh_mux_stage #(.W_IN(WI), .SHIFT(1 << s)) u_mux (
            .din  (g_stage[s-1].q),
            .sel  (off[s]),
            .dout (q)
         );
      end
   end

   assign res_o = g_stage[KW-1].q;

   always_comb begin
      if (!$isunknown({opnd_i, amt_i, mode_i})) begin
         a_r7_zero_amount_identity: assert (amt_i != '0 || mode_i[2:1] == 2'b11 || res_o == opnd_i)
            else $error("R7: zero amount altered operand");
         a_r8_reserved_pass: assert (mode_i[2:1] != 2'b11 || res_o == opnd_i)
            else $error("R8: reserved mode altered operand");
         a_r1_lsl_lsb_clear: assert (mode != SH_LSL || amt_i == '0 || !res_o[0])
            else $error("R1: logical left left a nonzero LSB");
         a_r3_asl_lsb_clear: assert (mode != SH_ASL || amt_i == '0 || !res_o[0])
            else $error("R3: arithmetic left left a nonzero LSB");
         a_r2_lsr_msb_clear: assert (mode != SH_LSR || amt_i == '0 || !res_o[N-1])
            else $error("R2: logical right left a nonzero MSB");
         a_r4_asr_sign_kept: assert (mode != SH_ASR || res_o[N-1] == opnd_i[N-1])
            else $error("R4: arithmetic right lost the sign");
         a_r5_rol_popcount: assert (mode != SH_ROL || $countones(res_o) == $countones(opnd_i))
            else $error("R5: rotate left changed bit count");
         a_r6_ror_popcount: assert (mode != SH_ROR || $countones(res_o) == $countones(opnd_i))
            else $error("R6: rotate right changed bit count");
      end
   end

endmodule

// File: tb/sim_fsh_funnel_shifter.sv
module sim_fsh_funnel_shifter;

   localparam int N  = 8;
   localparam int KW = $clog2(N);

   logic          clk = 1'b0;
   logic [N-1:0]  opnd;
   logic [KW-1:0] amt;
   logic [2:0]    mode;
   logic [N-1:0]  res;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fsh_funnel_shifter #(.N(N)) u0 (
      .opnd_i (opnd),
      .amt_i  (amt),
      .mode_i (mode),
      .res_o  (res)
   );

   function automatic logic [N-1:0] model(input int a, input int k, input int m);
      int mask = (1 << N) - 1;
      int sa   = (a >= (1 << (N - 1))) ? a - (1 << N) : a;
      case (m)
         0, 2:    return N'((a << k) & mask);
         1:       return N'(a >> k);
         3:       return N'((sa >>> k) & mask);
         4:       return N'(((a << k) | (a >> (N - k))) & mask);
         5:       return N'(((a >> k) | (a << (N - k))) & mask);
         default: return N'(a);
      endcase
   endfunction

   function automatic string tag(input int k, input int m);
      if (m >= 6) return "R8";
      if (k == 0) return "R7";
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [N-1:0] exp);
      checks++;
      if (res !== exp) begin
         errors++;
         $display("FAIL %s: opnd=%h amt=%0d mode=%0d actual=%h expected=%h",
                  req, opnd, amt, mode, res, exp);
      end
   endtask

   initial begin
      opnd = '0;
      amt  = '0;
      mode = '0;
      @(negedge clk);
      // R7: quiescent inputs give the operand back
      check("R7", '0);
      // exhaustive sweep: R1..R8, each result taken half a cycle after drive
      for (int m = 0; m < 8; m++) begin
         for (int k = 0; k < N; k++) begin
            for (int a = 0; a < (1 << N); a++) begin
               @(posedge clk);
               opnd = N'(a);
               amt  = KW'(k);
               mode = 3'(m);
               @(negedge clk);
               check(tag(k, m), model(a, k, m));
            end
         end
      end
      // R9: no state, output settles within the cycle after a change
      @(posedge clk);
      opnd = 8'hB3;
      amt  = 3'd3;
      mode = 3'd5;
      #1;
      check("R9", model(32'hB3, 3, 5));
      mode = 3'd3;
      #1;
      check("R9", model(32'hB3, 3, 3));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule